// File: doc/BRIEF.md
# Double-Buffered Multi-Channel PWM Bank

A bank of independent pulse-width generators behind a small 32-bit register bus. Each channel holds a period count, a first-phase count and a control word. Software writes land in shadow registers and never disturb the waveform directly. Setting the update bit in a control write commits the shadow period, first-phase count and first-phase level into a pending set. The pending set moves into the active set at the next period boundary, so a period that is already under way always completes with the values it started with. A stopped channel has no waveform to protect, so it takes the committed set on the next cycle.

A channel is launched by a control write that has both the start bit and the continuous bit set. After that it runs until reset. To idle a running channel, software commits a first-phase count of zero with the first-phase level high, which gives a steady low output. The first-phase level bit selects polarity. When it is 1 the output is high for the first `duty` cycles of each period. When it is 0 the output is low for those cycles.

Each channel is sequenced by a three-state machine:
- `CH_STOPPED`: the channel is not counting and its output is low.
- `CH_RUNNING`: the channel is counting and nothing is pending.
- `CH_ARMED`: the channel is counting and a committed set is waiting for the period boundary.

The transitions are:
- *launch*: from `CH_STOPPED` to `CH_RUNNING`, on start together with continuous.
- *commit*: from `CH_RUNNING` to `CH_ARMED`, on an update write.
- *apply*: from `CH_ARMED` to `CH_RUNNING`, at the boundary when no new update arrives in the same cycle.
- *recommit*: `CH_ARMED` stays in `CH_ARMED` when an update arrives.

Top module: `pwm_bank`

## Requirements
- R1: The bus uses word addresses. Channel c occupies words 8c to 8c+7. Its control register is at word 8c, its period at word 8c+2 and its first-phase count at word 8c+3. Reading the period or first-phase count returns the value last written.
- R2: The control fields are: bit 0 start, bit 2 update, bit 5 continuous, bit 8 first-phase level. On readback, bit 2 is always 0, bits 5 and 8 show the last written values, and bit 0 is 1 exactly when the channel is running. All other bits read 0.
- R3: Words at or above 8·(channels−1)+4 (word 44, byte 0xB0, with six channels) read as zero, and writes to them change nothing. Unused words inside the window (offsets 1 and 4 to 7) also read as zero.
- R4: After reset every output is low, every register reads zero and every channel is stopped.
- R5: A stopped channel drives 0. An update written while the channel is stopped makes the committed values active on the next cycle.
- R6: Start launches a stopped channel only when the same control write also sets continuous. Start is set-only: a control write without start never stops a running channel.
- R7: A running channel counts 0 to period−1 and then wraps. The output equals the first-phase level while count < duty and its inverse otherwise. The first write-cycle after launch shows count 0.
- R8: If duty ≥ period, the output holds the first-phase level for the whole period. A duty of 0 with the first-phase level at 1 gives a steady low.
- R9: A running channel with period 0 holds the inverse of the first-phase level.
- R10: An update written while the channel runs takes effect only on the cycle after the counter reaches period−1. Cycles before that use the old period, duty and level.
- R11: Writes to one channel do not alter another channel's registers or output.
- R12: Read data appears on `rdata` in the cycle after `rd_en` is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
A write or update captured at a rising edge is visible on `pwm_out` when sampled half a cycle later. Read data is checked half a cycle after the edge that follows the read strobe. A mid-run update leaves the old waveform in place for the remaining cycles of the current period. The new values show in the cycle after the counter reaches period−1. The bench drives every access on a falling edge. It pushes the expected pin value for each cycle, or the expected read word, into queues. A monitor samples 1 ns after each falling edge and pops one entry per cycle, so each expectation lines up with the cycle in which the result is due.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int CTRL_START = 0;
    localparam int CTRL_UPD   = 2;
    localparam int CTRL_CONT  = 5;
    localparam int CTRL_FPLVL = 8;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_PER  = 3'd2;
    localparam logic [2:0] REG_DUTY = 3'd3;

    typedef enum logic [1:0] {
        CH_STOPPED = 2'd0,
        CH_RUNNING = 2'd1,
        CH_ARMED   = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pwm_addr_dec.sv
`timescale 1ns/1ps
module pwm_addr_dec
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic [ADDR_W-4:0] sel_ch,
    output logic [2:0]        sel_reg,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic [NUM_CH-1:0] wr_per,
    output logic [NUM_CH-1:0] wr_duty
);
    localparam int SEL_W = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'((NUM_CH - 1) * 8 + 4);

    assign sel_ch    = addr[ADDR_W-1:3];
    assign sel_reg   = addr[2:0];
    assign in_window = addr < WIN_END;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        logic hit;
        assign hit        = wr_en && in_window && (sel_ch == SEL_W'(g));
        assign wr_ctrl[g] = hit && (sel_reg == REG_CTRL);
        assign wr_per[g]  = hit && (sel_reg == REG_PER);
        assign wr_duty[g] = hit && (sel_reg == REG_DUTY);
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_per,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] per_rd,
    output logic [DATA_W-1:0] duty_rd,
    output logic              pwm_o
);
    ch_state_e        state_q, state_d;
    logic             sh_cont, sh_fplvl;
    logic [CNT_W-1:0] sh_per, sh_duty;
    logic [CNT_W-1:0] pd_per, pd_duty;
    logic             pd_fplvl;
    logic [CNT_W-1:0] ac_per, ac_duty;
    logic             ac_fplvl;
    logic [CNT_W-1:0] cnt_q;
    logic             upd, go, boundary, load_idle, load_wrap;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;
    assign upd       = wr_ctrl && wdata[CTRL_UPD];
    assign go        = wr_ctrl && wdata[CTRL_START] && wdata[CTRL_CONT];
    assign boundary  = (ac_per == '0) || (cnt_q == (ac_per - CNT_W'(1)));
    assign load_idle = (state_q == CH_STOPPED) && upd;
    assign load_wrap = (state_q == CH_ARMED) && boundary;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (go) state_d = CH_RUNNING;
            CH_RUNNING: if (upd) state_d = CH_ARMED;
            CH_ARMED:   if (boundary && !upd) state_d = CH_RUNNING;
            default:    state_d = CH_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // shadow, pending and active register sets plus the period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cont  <= 1'b0;
            sh_fplvl <= 1'b0;
            sh_per   <= '0;
            sh_duty  <= '0;
            pd_per   <= '0;
            pd_duty  <= '0;
            pd_fplvl <= 1'b0;
            ac_per   <= '0;
            ac_duty  <= '0;
            ac_fplvl <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                sh_cont  <= wdata[CTRL_CONT];
                sh_fplvl <= wdata[CTRL_FPLVL];
            end
            if (wr_per)  sh_per  <= wdata[CNT_W-1:0];
            if (wr_duty) sh_duty <= wdata[CNT_W-1:0];
            if (upd) begin
                pd_per   <= sh_per;
                pd_duty  <= sh_duty;
                pd_fplvl <= wdata[CTRL_FPLVL];
            end
            if (load_idle) begin
                ac_per   <= sh_per;
                ac_duty  <= sh_duty;
                ac_fplvl <= wdata[CTRL_FPLVL];
            end else if (load_wrap) begin
                ac_per   <= pd_per;
                ac_duty  <= pd_duty;
                ac_fplvl <= pd_fplvl;
            end
            if (state_q == CH_STOPPED || boundary) cnt_q <= '0;
            else                                   cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[CTRL_START] = (state_q != CH_STOPPED);
        ctrl_rd[CTRL_CONT]  = sh_cont;
        ctrl_rd[CTRL_FPLVL] = sh_fplvl;
        unique case (state_q)
            CH_RUNNING, CH_ARMED: begin
                if (ac_per == '0)          pwm_o = !ac_fplvl;
                else if (cnt_q < ac_duty)  pwm_o = ac_fplvl;
                else                       pwm_o = !ac_fplvl;
            end
            default: pwm_o = 1'b0;
        endcase
    end

    assign per_rd  = DATA_W'(sh_per);
    assign duty_rd = DATA_W'(sh_duty);

    assert_stopped_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOPPED) |-> !pwm_o);
    assert_idle_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOPPED && upd) |=> (ac_per == $past(sh_per)) && (ac_duty == $past(sh_duty)));
    assert_start_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_STOPPED) |=> (state_q != CH_STOPPED));
    assert_count_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_STOPPED && ac_per != '0) |-> (cnt_q < ac_per));
    assert_hold_midperiod_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_STOPPED && !boundary) |=> ($stable(ac_per) && $stable(ac_duty) && $stable(ac_fplvl)));
    assert_arm_on_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUNNING && upd) |=> (state_q == CH_ARMED));
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int SEL_W = ADDR_W - 3;

    logic              in_window;
    logic [SEL_W-1:0]  sel_ch;
    logic [2:0]        sel_reg;
    logic [NUM_CH-1:0] wr_ctrl, wr_per, wr_duty;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] per_rd  [NUM_CH];
    logic [DATA_W-1:0] duty_rd [NUM_CH];
    logic [DATA_W-1:0] rdata_q;

    pwm_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .in_window (in_window),
        .sel_ch    (sel_ch),
        .sel_reg   (sel_reg),
        .wr_ctrl   (wr_ctrl),
        .wr_per    (wr_per),
        .wr_duty   (wr_duty)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[c]),
            .wr_per  (wr_per[c]),
            .wr_duty (wr_duty[c]),
            .wdata   (wdata),
            .ctrl_rd (ctrl_rd[c]),
            .per_rd  (per_rd[c]),
            .duty_rd (duty_rd[c]),
            .pwm_o   (pwm_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            if (!in_window) begin
                rdata_q <= '0;
            end else begin
                case (sel_reg)
                    REG_CTRL: rdata_q <= ctrl_rd[sel_ch];
                    REG_PER:  rdata_q <= per_rd[sel_ch];
                    REG_DUTY: rdata_q <= duty_rd[sel_ch];
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign rdata = rdata_q;

    assert_oob_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_window) |=> (rdata == '0));
    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctrl, wr_per, wr_duty}));
    assert_oob_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_window) |-> ({wr_ctrl, wr_per, wr_duty} == '0));
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pwm_out;

    int checks = 0;
    int fails  = 0;

    logic [5:0]  wv_q[$];
    logic [5:0]  wm_q[$];
    string       wt_q[$];
    logic [31:0] rx_q[$];
    string       rt_q[$];
    logic        rd_due = 1'b0;

    always #5 clk = ~clk;

    pwm_bank u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    always @(posedge clk) rd_due <= rd_en;

    task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one read result and one pin sample per cycle
    always @(negedge clk) begin
        logic [31:0] e;
        logic [5:0]  v, m;
        string       t;
        #1;
        if (rd_due && rx_q.size() > 0) begin
            e = rx_q.pop_front();
            t = rt_q.pop_front();
            note(rdata === e, t, rdata, e);
        end
        if (wv_q.size() > 0) begin
            v = wv_q.pop_front();
            m = wm_q.pop_front();
            t = wt_q.pop_front();
            note((pwm_out & m) === (v & m), t, 32'(pwm_out & m), 32'(v & m));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        rx_q.push_back(exp);
        rt_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expw(input logic [5:0] v, input logic [5:0] m, input string tag);
        wv_q.push_back(v);
        wm_q.push_back(m);
        wt_q.push_back(tag);
    endtask

    task automatic drain();
        while (wv_q.size() != 0 || rx_q.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        note(pwm_out === 6'b0, "R4 outputs low in reset", 32'(pwm_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 32'h0, "R4 ch0 control after reset");
        rd(2, 32'h0, "R4 ch0 period after reset");
        rd(3, 32'h0, "R4 ch0 duty after reset");

        // R1 register map and readback, R12 one-cycle read latency
        wr(34, 32'h1234_5678);
        wr(35, 32'h0000_00A5);
        wr(43, 32'hCAFE_0001);
        rd(34, 32'h1234_5678, "R1 R12 ch4 period readback");
        rd(35, 32'h0000_00A5, "R1 ch4 duty readback");
        rd(43, 32'hCAFE_0001, "R1 ch5 duty at last word");

        // R3 out-of-window and unused words
        wr(44, 32'hFFFF_FFFF);
        wr(48, 32'h0000_0121);
        rd(44, 32'h0, "R3 first word past window");
        rd(48, 32'h0, "R3 nonexistent channel");
        rd(63, 32'h0, "R3 top word");
        rd(1,  32'h0, "R3 unused word inside window");
        rd(43, 32'hCAFE_0001, "R3 stray write left ch5 duty");
        rd(40, 32'h0, "R3 ch5 not started by stray write");
        expw(6'b0, 6'b100000, "R3 ch5 output still idle");
        drain();

        // R6 start without continuous is ignored; R5 stopped output low
        wr(10, 32'd5);
        wr(11, 32'd5);
        wr(8, 32'h0000_0104);
        wr(8, 32'h0000_0001);
        for (int i = 0; i < 4; i++) expw(6'b0, 6'b000010, "R6 R5 ch1 stays stopped and low");
        drain();
        rd(8, 32'h0, "R6 ch1 control shows stopped");
        drain();

        // R2 control readback, R5 R7 first period, R10 deferred update
        wr(2, 32'd5);
        wr(3, 32'd2);
        wr(0, 32'h0000_0124);
        rd(0, 32'h0000_0120, "R2 update bit reads 0, start 0");
        wr(0, 32'h0000_0121);
        for (int i = 0; i < 12; i++) begin
            logic b;
            if (i < 5) b = (i < 2);
            else       b = (((i - 5) % 3) < 1);
            expw({5'b0, b}, 6'b000001, (i < 5) ? "R5 R7 R10 ch0 period with old values"
                                               : "R10 ch0 new values after wrap");
        end
        wr(2, 32'd3);
        wr(3, 32'd1);
        wr(0, 32'h0000_0124);
        drain();
        rd(0, 32'h0000_0121, "R2 R6 start bit reads 1 after control write without start");
        drain();

        // R7 inverted polarity on ch1
        wr(10, 32'd4);
        wr(11, 32'd1);
        wr(8, 32'h0000_0024);
        wr(8, 32'h0000_0021);
        for (int i = 0; i < 8; i++)
            expw({4'b0, ((i % 4) < 1) ? 1'b0 : 1'b1, 1'b0}, 6'b000010, "R7 first-phase level 0 inverts");
        drain();

        // R8 duty >= period on ch2, R9 period 0 on ch3
        wr(18, 32'd3);
        wr(19, 32'd7);
        wr(16, 32'h0000_0124);
        wr(16, 32'h0000_0121);
        wr(26, 32'd0);
        wr(27, 32'd0);
        wr(24, 32'h0000_0024);
        wr(24, 32'h0000_0021);
        for (int i = 0; i < 6; i++) expw(6'b001100, 6'b001100, "R8 full-period high, R9 zero period inactive");
        drain();
        rd(24, 32'h0000_0021, "R9 zero-period channel reports running");
        drain();

        // R8 duty 0 idles ch0 low; R11 ch2 unaffected
        wr(3, 32'd0);
        wr(0, 32'h0000_0124);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) expw(6'b000100, 6'b000101, "R8 duty 0 steady low, R11 ch2 unchanged");
        drain();
        rd(10, 32'd4, "R11 ch1 period untouched by ch0 writes");
        rd(11, 32'd1, "R11 ch1 duty untouched by ch0 writes");
        drain();

        summary();
        $finish;
    end
endmodule